// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer with Return Stack

This block chooses the control-memory address for a microprogrammed control unit. Every cycle it receives the sequencing fields of the current microword: a 3-bit next-address opcode, a branch target, a 4-bit index that picks one of sixteen status conditions, and a polarity bit. The selected condition is optionally inverted by the polarity bit, and the result decides whether a conditional operation is taken.

The block keeps a microprogram counter, presented as the registered output `uaddr`. The next address is one of three values: the counter plus one, the branch target, or the entry on top of a return-address stack. A call branches and pushes the address after the calling instruction, and a return resumes at the most recently pushed address. Calls can nest up to the stack depth.

A return reads the top entry at once. The pointer decrement is applied in the following cycle, and back-to-back stack operations still see the correct pointer. Two sticky flags report a push onto a full stack and a pop from an empty one.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high reset drives `uaddr` to 0, empties the stack and clears `stk_ovf` and `stk_unf`. All of these are visible one clock edge after `rst` is sampled high.
- R2: Opcode 0 (continue) loads `uaddr` with `uaddr + 1` modulo 2^AW on the next edge.
- R3: Opcode 1 (jump) loads `uaddr` with `br_target` on the next edge.
- R4: The test result is `cond_vec[cond_sel] XOR cond_inv`. Opcodes 2 (jump if), 4 (call if) and 6 (return if) are taken exactly when this result is 1.
- R5: When the test of opcode 2, 4 or 6 fails, `uaddr` becomes `uaddr + 1` and the stack is left unchanged.
- R6: A taken call (opcode 3, or 4 with a passing test) loads `uaddr` with `br_target` and pushes `uaddr + 1`.
- R7: A taken return (opcode 5, or 6 with a passing test) loads `uaddr` with the most recently pushed address that is still on the stack. Nested calls return in strict reverse order.
- R8: Returns and calls issued in consecutive cycles see a pointer that already includes the pending decrement from the previous return.
- R9: A taken call made when DEPTH entries are held sets `stk_ovf`, which stays set until reset. The call still branches, and no stored entry is overwritten.
- R10: A taken return made when the stack is empty sets `stk_unf`, which stays set until reset, and loads `uaddr` with 0.
- R11: Opcode 7 (hold) leaves `uaddr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| na_op | input | 3 | Next-address opcode |
| br_target | input | AW | Branch or call target address |
| cond_sel | input | 4 | Index of the tested status condition |
| cond_inv | input | 1 | 1 inverts the selected condition |
| cond_vec | input | 16 | External status conditions |
| uaddr | output | AW | Current control-memory address (registered) |
| stk_ovf | output | 1 | Sticky push-on-full flag |
| stk_unf | output | 1 | Sticky pop-on-empty flag |

## Verification
A directed prologue covers increments, a jump, nine nested calls and nine returns. This separates correct LIFO ordering from FIFO or off-by-one pointer errors, and it shows the overflow entry is not overwritten and that an empty return goes to address 0. Explicit condition patterns with both polarities separate true-taken from false-taken. Two pseudo-random sweeps then apply every combination of opcode, select index and polarity, with mixed status words and targets. These runs produce dense back-to-back call and return sequences, which expose any error in the deferred pointer decrement.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    OP_CONT  = 3'd0,
    OP_JMP   = 3'd1,
    OP_JMPC  = 3'd2,
    OP_CALL  = 3'd3,
    OP_CALLC = 3'd4,
    OP_RET   = 3'd5,
    OP_RETC  = 3'd6,
    OP_HOLD  = 3'd7
  } na_op_e;

  typedef enum logic [2:0] {
    SRC_INC  = 3'd0,
    SRC_TGT  = 3'd1,
    SRC_TOS  = 3'd2,
    SRC_ZERO = 3'd3,
    SRC_SAME = 3'd4
  } na_src_e;

endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel #(
  parameter int NCOND = 16,
  localparam int SW = $clog2(NCOND)
) (
  input  logic [NCOND-1:0] cond_vec,
  input  logic [SW-1:0]    cond_sel,
  input  logic             cond_inv,
  output logic             test_ok
);

  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NCOND; i++) begin
      if (cond_sel == SW'(i)) picked = cond_vec[i];
    end
    test_ok = picked ^ cond_inv;
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  logic [2:0] na_op,
  input  logic       test_ok,
  input  logic       stk_empty,
  input  logic       stk_full,
  output na_src_e    src,
  output logic       push,
  output logic       pop,
  output logic       ovf_set,
  output logic       unf_set
);

  logic call_go, ret_go;

  always_comb begin
    src     = SRC_INC;
    call_go = 1'b0;
    ret_go  = 1'b0;
    unique case (na_op_e'(na_op))
      OP_CONT:  src = SRC_INC;
      OP_JMP:   src = SRC_TGT;
      OP_JMPC:  src = test_ok ? SRC_TGT : SRC_INC;
      OP_CALL:  call_go = 1'b1;
      OP_CALLC: call_go = test_ok;
      OP_RET:   ret_go = 1'b1;
      OP_RETC:  ret_go = test_ok;
      OP_HOLD:  src = SRC_SAME;
      default:  src = SRC_INC;
    endcase
    if (call_go) src = SRC_TGT;
    if (ret_go)  src = stk_empty ? SRC_ZERO : SRC_TOS;
    push    = call_go & ~stk_full;
    ovf_set = call_go & stk_full;
    pop     = ret_go & ~stk_empty;
    unf_set = ret_go & stk_empty;
  end

endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
  parameter int AW    = 10,
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic          empty,
  output logic          full
);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] cnt;
  logic          pend_dec;
  logic [PW-1:0] eff;
  logic [IW-1:0] wr_idx, rd_idx;

  // Pointer value with the deferred decrement of the previous return applied
  assign eff    = cnt - {{(PW-1){1'b0}}, pend_dec};
  assign wr_idx = IW'(eff);
  assign rd_idx = IW'(eff - PW'(1));
  assign empty  = (eff == '0);
  assign full   = (eff == PW'(DEPTH));
  assign rdata  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      pend_dec <= 1'b0;
    end else begin
      pend_dec <= pop;
      cnt      <= push ? eff + PW'(1) : eff;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= wdata;
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DEPTH = 8,
  parameter int NCOND = 16,
  localparam int SW = $clog2(NCOND)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       na_op,
  input  logic [AW-1:0]    br_target,
  input  logic [SW-1:0]    cond_sel,
  input  logic             cond_inv,
  input  logic [NCOND-1:0] cond_vec,
  output logic [AW-1:0]    uaddr,
  output logic             stk_ovf,
  output logic             stk_unf
);

  logic          test_ok;
  logic          stk_empty, stk_full;
  logic          push, pop, ovf_set, unf_set;
  na_src_e       src;
  logic [AW-1:0] upc_inc, tos_addr, nxt;

  assign upc_inc = uaddr + AW'(1);

  useq_cond_sel #(.NCOND(NCOND)) u_cond (
    .cond_vec (cond_vec),
    .cond_sel (cond_sel),
    .cond_inv (cond_inv),
    .test_ok  (test_ok)
  );

  useq_next_addr u_dec (
    .na_op     (na_op),
    .test_ok   (test_ok),
    .stk_empty (stk_empty),
    .stk_full  (stk_full),
    .src       (src),
    .push      (push),
    .pop       (pop),
    .ovf_set   (ovf_set),
    .unf_set   (unf_set)
  );

  useq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .wdata (upc_inc),
    .rdata (tos_addr),
    .empty (stk_empty),
    .full  (stk_full)
  );

  always_comb begin
    unique case (src)
      SRC_TGT:  nxt = br_target;
      SRC_TOS:  nxt = tos_addr;
      SRC_ZERO: nxt = '0;
      SRC_SAME: nxt = uaddr;
      default:  nxt = upc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr   <= '0;
      stk_ovf <= 1'b0;
      stk_unf <= 1'b0;
    end else begin
      uaddr   <= nxt;
      stk_ovf <= stk_ovf | ovf_set;
      stk_unf <= stk_unf | unf_set;
    end
  end

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    na_op,
  input logic [AW-1:0] br_target,
  input logic [AW-1:0] uaddr,
  input logic          stk_ovf,
  input logic          stk_unf
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (uaddr == '0 && !stk_ovf && !stk_unf));

  p_cont_r2: assert property (@(posedge clk) disable iff (rst)
    (na_op == 3'd0) |=> (uaddr == $past(uaddr) + AW'(1)));

  p_jmp_r3: assert property (@(posedge clk) disable iff (rst)
    (na_op == 3'd1) |=> (uaddr == $past(br_target)));

  p_call_r6: assert property (@(posedge clk) disable iff (rst)
    (na_op == 3'd3) |=> (uaddr == $past(br_target)));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);

  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    stk_unf |=> stk_unf);

  p_unf_zero_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_unf) |-> (uaddr == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (na_op == 3'd7) |=> $stable(uaddr));

endmodule

bind useq_sequencer useq_sequencer_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .na_op     (na_op),
  .br_target (br_target),
  .uaddr     (uaddr),
  .stk_ovf   (stk_ovf),
  .stk_unf   (stk_unf)
);

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;

  localparam int AW = 10;
  localparam int D  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    na_op = '0;
  logic [AW-1:0] br_target = '0;
  logic [3:0]    cond_sel = '0;
  logic          cond_inv = 1'b0;
  logic [15:0]   cond_vec = '0;
  logic [AW-1:0] uaddr;
  logic          stk_ovf, stk_unf;

  always #10 clk = ~clk;

  useq_sequencer #(.AW(AW), .DEPTH(D), .NCOND(16)) uut (
    .clk(clk), .rst(rst), .na_op(na_op), .br_target(br_target),
    .cond_sel(cond_sel), .cond_inv(cond_inv), .cond_vec(cond_vec),
    .uaddr(uaddr), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  // Reference model state
  logic [AW-1:0] m_addr;
  logic [AW-1:0] m_stk [D];
  int            m_cnt;
  bit            m_ovf, m_unf;
  logic [15:0]   lf = 16'hACE1;

  task automatic check(input string tag, input logic [AW-1:0] a, input logic [AW-1:0] e,
                       input bit fo, input bit eo, input bit fu, input bit eu);
    vecs++;
    if (a !== e || fo !== eo || fu !== eu) begin
      bad++;
      $display("FAIL %s: addr=%0d ovf=%0b unf=%0b expected addr=%0d ovf=%0b unf=%0b",
               tag, a, fo, fu, e, eo, eu);
    end
  endtask

  task automatic model_reset();
    m_addr = '0; m_cnt = 0; m_ovf = 0; m_unf = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    model_reset();
    check("R1", uaddr, '0, stk_ovf, 1'b0, stk_unf, 1'b0);
    rst = 1'b0;
  endtask

  task automatic apply(input logic [2:0] op, input logic [AW-1:0] tgt,
                       input logic [3:0] sel, input bit inv, input logic [15:0] cv);
    bit            t, call_go, ret_go;
    logic [AW-1:0] inc, nx;
    string         tag;
    na_op = op; br_target = tgt; cond_sel = sel; cond_inv = inv; cond_vec = cv;
    t = cv[sel] ^ inv;
    inc = m_addr + AW'(1);
    nx = inc;
    call_go = 0; ret_go = 0;
    case (op)
      3'd0: begin nx = inc; tag = "R2"; end
      3'd1: begin nx = tgt; tag = "R3"; end
      3'd2: begin nx = t ? tgt : inc; tag = t ? "R4" : "R5"; end
      3'd3: begin call_go = 1; tag = "R6"; end
      3'd4: begin call_go = t; tag = t ? "R4" : "R5"; end
      3'd5: begin ret_go = 1; tag = "R7"; end
      3'd6: begin ret_go = t; tag = t ? "R8" : "R5"; end
      default: begin nx = m_addr; tag = "R11"; end
    endcase
    if (call_go) begin
      nx = tgt;
      if (m_cnt == D) begin m_ovf = 1; tag = "R9"; end
      else begin m_stk[m_cnt] = inc; m_cnt++; end
    end
    if (ret_go) begin
      if (m_cnt == 0) begin m_unf = 1; nx = '0; tag = "R10"; end
      else begin m_cnt--; nx = m_stk[m_cnt]; end
    end
    m_addr = nx;
    @(posedge clk);
    @(negedge clk);
    check(tag, uaddr, m_addr, stk_ovf, m_ovf, stk_unf, m_unf);
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic sweep();
    for (int op = 0; op < 8; op++)
      for (int s = 0; s < 16; s++)
        for (int inv = 0; inv < 2; inv++) begin
          lf = step(lf);
          apply(3'(op), AW'(lf), 4'(s), inv[0], lf ^ 16'h5A3C);
          lf = step(lf);
          apply(3'(lf[2:0]), AW'(lf >> 3), lf[7:4], lf[8], step(lf));
        end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2 increments, R3 jump
    for (int i = 0; i < 3; i++) apply(3'd0, '0, '0, 0, '0);
    apply(3'd1, 10'd100, '0, 0, '0);
    // R6/R7/R9: nine nested calls, ninth overflows
    for (int i = 0; i < 9; i++) apply(3'd3, AW'(200 + i * 10), '0, 0, '0);
    // R7/R8 returns back to back, last one underflows (R10)
    for (int i = 0; i < 9; i++) apply(3'd5, '0, '0, 0, '0);
    apply(3'd7, 10'd55, '0, 0, '0);
    apply(3'd7, 10'd56, '0, 0, '0);
    do_reset();
    // R4 polarity, R5 fall-through
    apply(3'd2, 10'd300, 4'd5, 0, 16'h0020);
    apply(3'd2, 10'd400, 4'd5, 1, 16'h0020);
    apply(3'd2, 10'd500, 4'd9, 1, 16'h0000);
    apply(3'd4, 10'd600, 4'd9, 0, 16'h0000);
    apply(3'd4, 10'd700, 4'd15, 0, 16'h8000);
    apply(3'd6, 10'd0, 4'd15, 1, 16'h8000);
    apply(3'd3, 10'd800, '0, 0, '0);
    apply(3'd6, 10'd0, 4'd0, 1, 16'h0000);
    apply(3'd6, 10'd0, 4'd0, 1, 16'h0000);
    // R2 wrap
    apply(3'd1, 10'd1023, '0, 0, '0);
    apply(3'd0, '0, '0, 0, '0);
    do_reset();
    sweep();
    do_reset();
    lf = 16'h1F2E;
    sweep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule